// File: doc/BRIEF.md
# Microcoded Bus Strobe Generator

This block produces the control strobes of an external memory bus from a small microprogram that software loads. The microcode store has 64 words of 32 bits. While a sequence runs, one word sets the strobes for one bus clock cycle. The block runs on a clock four times faster than the bus clock, so each word can set the chip-select and byte-select levels separately in each quarter of the bus cycle. Each word also sets six general-purpose control lines for the whole bus cycle.

A host port writes the store and reads it back. The access side supplies:
- a request pulse,
- a start index into the store,
- a one-hot bank hit that picks one of eight chip selects,
- the port size of that bank,
- the two lowest address bits.

From the port size and the address bits the block works out which of four byte lanes take part in the access. The sequencer then runs words from the start index until it has executed a word with the last flag set. At that point it pulses done and goes back to idle.

Microword layout:

| Bits | Use |
|------|-----|
| 3:0 | Chip-select enables for each quarter phase. Bit 0 is the first quarter and bit 3 is the fourth. |
| 7:4 | Byte-select enables, in the same phase order. |
| 13:8 | General-purpose line levels. |
| 30:14 | Unused. |
| 31 | Last-word flag. |

An enable bit of 1 asserts the strobe (drives it low).

Top module: `ustrb_top`

## Requirements
- R1: The host port writes `host_wdata` into word `host_addr` on a clock edge where `host_we` is high and the block is idle. `host_rdata` shows the word at `host_addr` one clock after the address is applied.
- R2: A `req_valid` sampled while idle starts a sequence at word `req_start`. The first quarter phase of that word appears on the outputs one clock after the accepting edge. Each word lasts four clocks, and the index then advances by one, wrapping from 63 to 0. The sequence ends after the fourth clock of a word whose bit 31 is 1.
- R3: During quarter phase p (0 to 3) of a word, the chip select whose `req_bank` bit was set at acceptance is low exactly when bit p of the word is 1. All other chip selects stay high.
- R4: Byte lanes are chosen at acceptance from `req_psize` and `req_addr_lo`. The size codes are:
  - 2'b01 (8-bit port): only lane `req_addr_lo`.
  - 2'b10 (16-bit port): lanes 0 and 1 when `req_addr_lo[1]` is 0, otherwise lanes 2 and 3.
  - 2'b11 (32-bit port): all four lanes.
  - 2'b00: no lane.

  Lane i is `bs_n[i]`.
- R5: During quarter phase p, each selected lane is low exactly when bit 4+p of the word is 1. Unselected lanes stay high.
- R6: During all four phases of a word, `gpl` equals bits 13:8 of that word.
- R7: `done` is high for exactly one clock, the clock in which the fourth phase of the last word is on the outputs.
- R8: After reset and whenever the block is idle:
  - all `cs_n` and `bs_n` bits are high,
  - `gpl` is 0,
  - `done` and `busy` are low.
- R9: `busy` is high from the clock after acceptance until the sequence ends. A host write made while `busy` is high leaves the store unchanged.
- R10: A `req_valid` made while `busy` is high is ignored. The running sequence goes on unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, four times the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 6 | Host word index |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered read-back of the word at `host_addr` |
| req_valid | input | 1 | Access request pulse |
| req_start | input | 6 | First microword index |
| req_bank | input | 8 | One-hot bank hit |
| req_psize | input | 2 | Port size code of the bank |
| req_addr_lo | input | 2 | Two lowest address bits |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-clock end-of-sequence pulse |
| cs_n | output | 8 | Chip selects, active low |
| bs_n | output | 4 | Byte selects, active low |
| gpl | output | 6 | General-purpose control lines |

## Verification
The assertions assume three things about the inputs:
- `req_bank` is one-hot whenever a request is accepted.
- Every microprogram reached from a start index meets a word with the last flag. Otherwise the sequencer never returns to idle.
- A host write does not share a cycle with an accepted request.

The bench stays within these limits:
- It draws banks only as a single shifted bit.
- It forces the last flag on every eighth word of the random store contents.
- It drives host writes during a run only on a clock after the request has been taken.

// File: rtl/ustrb_pkg.sv
package ustrb_pkg;
  localparam int UW_W    = 32;
  localparam int PHASES  = 4;
  localparam int GPL_CNT = 6;

  typedef struct packed {
    logic                last;
    logic [16:0]         spare;
    logic [GPL_CNT-1:0]  gpl;
    logic [PHASES-1:0]   bs_t;
    logic [PHASES-1:0]   cs_t;
  } uword_t;

  typedef enum logic [1:0] {
    PSZ_NONE = 2'b00,
    PSZ_8    = 2'b01,
    PSZ_16   = 2'b10,
    PSZ_32   = 2'b11
  } psize_e;

  typedef enum logic {
    SQ_IDLE = 1'b0,
    SQ_RUN  = 1'b1
  } sq_state_e;
endpackage

// File: rtl/ustrb_ram.sv
module ustrb_ram #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic             lock,
  input  logic [AW-1:0]    host_addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] host_rdata,
  input  logic [AW-1:0]    seq_addr,
  output logic [WIDTH-1:0] seq_rdata
);
  logic [WIDTH-1:0] store_q [DEPTH];
  logic             store_en;
  logic [WIDTH-1:0] rdata_d;
  logic [WIDTH-1:0] rdata_q;

  assign store_en = we && !lock;

  always_ff @(posedge clk) begin
    if (store_en) begin
      store_q[host_addr] <= wdata;
    end
  end

  assign rdata_d   = store_q[host_addr];
  assign seq_rdata = store_q[seq_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= rdata_d;
    end
  end

  assign host_rdata = rdata_q;
endmodule

// File: rtl/ustrb_lane_dec.sv
module ustrb_lane_dec
  import ustrb_pkg::*;
#(
  parameter int LANES = 4,
  localparam int LW = $clog2(LANES)
) (
  input  psize_e           psize,
  input  logic [LW-1:0]    addr_lo,
  output logic [LANES-1:0] lanes
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [LW-1:0] IDX = LW'(i);
    always_comb begin
      unique case (psize)
        PSZ_8:   lanes[i] = (addr_lo == IDX);
        PSZ_16:  lanes[i] = (addr_lo[LW-1] == IDX[LW-1]);
        PSZ_32:  lanes[i] = 1'b1;
        default: lanes[i] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/ustrb_seq.sv
module ustrb_seq
  import ustrb_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int PHASES_P = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = $clog2(PHASES_P)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_req,
  input  logic [AW-1:0] start_idx,
  input  logic          word_last,
  output logic          accept,
  output logic          run,
  output logic          fin,
  output logic [AW-1:0] pc,
  output logic [PW-1:0] phase
);
  localparam logic [PW-1:0] PH_LAST = PW'(PHASES_P - 1);

  sq_state_e     state_q, state_d;
  logic [AW-1:0] pc_q, pc_d;
  logic [PW-1:0] ph_q, ph_d;

  always_comb begin
    accept  = (state_q == SQ_IDLE) && start_req;
    fin     = (state_q == SQ_RUN) && (ph_q == PH_LAST) && word_last;
    state_d = state_q;
    pc_d    = pc_q;
    ph_d    = ph_q;
    if (accept) begin
      state_d = SQ_RUN;
      pc_d    = start_idx;
      ph_d    = '0;
    end else if (state_q == SQ_RUN) begin
      ph_d = ph_q + 1'b1;
      if (fin) begin
        state_d = SQ_IDLE;
      end else if (ph_q == PH_LAST) begin
        pc_d = pc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      pc_q    <= '0;
      ph_q    <= '0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      ph_q    <= ph_d;
    end
  end

  assign run   = (state_q == SQ_RUN);
  assign pc    = pc_q;
  assign phase = ph_q;

  assert_phase_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !fin) |=> (run && phase == $past(phase) + 1'b1));
  assert_pc_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && phase != PH_LAST) |=> (pc == $past(pc)));
  assert_end_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !run);
endmodule

// File: rtl/ustrb_top.sv
module ustrb_top
  import ustrb_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int BANKS = 8,
  parameter int LANES = 4,
  parameter logic [GPL_CNT-1:0] GPL_IDLE = '0,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(LANES),
  localparam int PW = $clog2(PHASES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_we,
  input  logic [AW-1:0]      host_addr,
  input  logic [UW_W-1:0]    host_wdata,
  output logic [UW_W-1:0]    host_rdata,
  input  logic               req_valid,
  input  logic [AW-1:0]      req_start,
  input  logic [BANKS-1:0]   req_bank,
  input  logic [1:0]         req_psize,
  input  logic [LW-1:0]      req_addr_lo,
  output logic               busy,
  output logic               done,
  output logic [BANKS-1:0]   cs_n,
  output logic [LANES-1:0]   bs_n,
  output logic [GPL_CNT-1:0] gpl
);
  logic [UW_W-1:0]    seq_raw;
  uword_t             word;
  logic               accept, run, fin;
  logic [AW-1:0]      pc;
  logic [PW-1:0]      phase;
  logic [LANES-1:0]   lanes_dec;
  logic [BANKS-1:0]   bank_q;
  logic [LANES-1:0]   lanes_q;
  logic               cs_on, bs_on;
  logic [BANKS-1:0]   cs_n_d, cs_n_q;
  logic [LANES-1:0]   bs_n_d, bs_n_q;
  logic [GPL_CNT-1:0] gpl_d, gpl_q;
  logic               done_q;

  ustrb_ram #(.DEPTH(DEPTH), .WIDTH(UW_W)) ram_i (
    .clk(clk), .rst_n(rst_n), .we(host_we), .lock(run),
    .host_addr(host_addr), .wdata(host_wdata), .host_rdata(host_rdata),
    .seq_addr(pc), .seq_rdata(seq_raw)
  );

  assign word = uword_t'(seq_raw);

  ustrb_seq #(.DEPTH(DEPTH), .PHASES_P(PHASES)) seq_i (
    .clk(clk), .rst_n(rst_n), .start_req(req_valid), .start_idx(req_start),
    .word_last(word.last), .accept(accept), .run(run), .fin(fin),
    .pc(pc), .phase(phase)
  );

  ustrb_lane_dec #(.LANES(LANES)) lane_i (
    .psize(psize_e'(req_psize)), .addr_lo(req_addr_lo), .lanes(lanes_dec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q  <= '0;
      lanes_q <= '0;
    end else if (accept) begin
      bank_q  <= req_bank;
      lanes_q <= lanes_dec;
    end
  end

  always_comb begin
    cs_on = word.cs_t[phase];
    bs_on = word.bs_t[phase];
    if (run) begin
      cs_n_d = ~(bank_q & {BANKS{cs_on}});
      bs_n_d = ~(lanes_q & {LANES{bs_on}});
      gpl_d  = word.gpl;
    end else begin
      cs_n_d = '1;
      bs_n_d = '1;
      gpl_d  = GPL_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n_q <= '1;
      bs_n_q <= '1;
      gpl_q  <= GPL_IDLE;
      done_q <= 1'b0;
    end else begin
      cs_n_q <= cs_n_d;
      bs_n_q <= bs_n_d;
      gpl_q  <= gpl_d;
      done_q <= fin;
    end
  end

  assign cs_n = cs_n_q;
  assign bs_n = bs_n_q;
  assign gpl  = gpl_q;
  assign done = done_q;
  assign busy = run;

  assert_cs_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  assert_bs_in_lanes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((~bs_n & ~lanes_q) == '0));
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && (&cs_n) && (&bs_n)));
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !done && !$past(busy)) |-> ((&cs_n) && (&bs_n) && gpl == GPL_IDLE));
  assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: tb/ustrb_top_tb_top.sv
module ustrb_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_we;
  logic [5:0]  host_addr;
  logic [31:0] host_wdata;
  logic [31:0] host_rdata;
  logic        req_valid;
  logic [5:0]  req_start;
  logic [7:0]  req_bank;
  logic [1:0]  req_psize;
  logic [1:0]  req_addr_lo;
  logic        busy, done;
  logic [7:0]  cs_n;
  logic [3:0]  bs_n;
  logic [5:0]  gpl;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  logic [31:0] mdl [64];

  always #4 clk = ~clk;

  ustrb_top dut_i (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .req_valid(req_valid),
    .req_start(req_start), .req_bank(req_bank), .req_psize(req_psize),
    .req_addr_lo(req_addr_lo), .busy(busy), .done(done), .cs_n(cs_n),
    .bs_n(bs_n), .gpl(gpl)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_lanes(input logic [1:0] ps, input logic [1:0] a);
    case (ps)
      2'b01:   return 4'b0001 << a;
      2'b10:   return a[1] ? 4'b1100 : 4'b0011;
      2'b11:   return 4'b1111;
      default: return 4'b0000;
    endcase
  endfunction

  task automatic check_idle(input string tag);
    chk(cs_n == 8'hFF, {tag, " cs_n"}, 32'(cs_n), 32'hFF);
    chk(bs_n == 4'hF, {tag, " bs_n"}, 32'(bs_n), 32'hF);
    chk(gpl == 6'd0, {tag, " gpl"}, 32'(gpl), 32'd0);
    chk(!busy && !done, {tag, " busy/done"}, {busy, done}, 32'd0);
  endtask

  task automatic host_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(posedge clk);
    @(negedge clk);
    host_we = 1'b0;
    mdl[a] = d;
  endtask

  task automatic host_check(input logic [5:0] a, input string tag);
    @(negedge clk);
    host_addr = a;
    @(posedge clk);
    @(negedge clk);
    chk(host_rdata == mdl[a], tag, host_rdata, mdl[a]);
  endtask

  task automatic run_seq(input logic [5:0] start, input logic [7:0] bank,
                         input logic [1:0] ps, input logic [1:0] a, input bit disturb);
    logic [5:0]  pc;
    logic [3:0]  ln;
    logic [31:0] w;
    logic [5:0]  wa;
    bit          fin;
    ln = exp_lanes(ps, a);
    wa = 6'($urandom);
    @(negedge clk);
    req_valid = 1'b1; req_start = start; req_bank = bank;
    req_psize = ps; req_addr_lo = a;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy, "R9 busy after accept", 32'(busy), 32'd1);
    chk(cs_n == 8'hFF, "R2 no strobe on accept cycle", 32'(cs_n), 32'hFF);
    pc = start;
    fin = 0;
    for (int n = 0; n < 64 && !fin; n++) begin
      w = mdl[pc];
      for (int p = 0; p < 4; p++) begin
        if (disturb && n == 0 && p == 0) begin
          host_we = 1'b1; host_addr = wa; host_wdata = ~mdl[wa];
          req_valid = 1'b1; req_start = start + 6'd1;
          req_bank = {bank[6:0], bank[7]}; req_psize = 2'b11;
        end
        @(posedge clk);
        @(negedge clk);
        host_we = 1'b0; req_valid = 1'b0;
        chk(cs_n == ~(bank & {8{w[p]}}), "R3 cs_n phase", 32'(cs_n), 32'(~(bank & {8{w[p]}})));
        chk(bs_n == ~(ln & {4{w[4+p]}}), "R4 R5 bs_n phase", 32'(bs_n), 32'(~(ln & {4{w[4+p]}})));
        chk(gpl == w[13:8], "R6 gpl", 32'(gpl), 32'(w[13:8]));
        chk(done == (p == 3 && w[31]), "R7 done timing", 32'(done), 32'(p == 3 && w[31]));
        chk(busy == !(p == 3 && w[31]), "R9 busy during run", 32'(busy), 32'(!(p == 3 && w[31])));
      end
      if (w[31]) fin = 1; else pc = pc + 6'd1;
    end
    @(posedge clk);
    @(negedge clk);
    check_idle("R8 R10 idle after sequence");
    if (disturb) host_check(wa, "R9 blocked write kept old word");
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; host_we = 1'b0; host_addr = '0; host_wdata = '0;
    req_valid = 1'b0; req_start = '0; req_bank = 8'h01; req_psize = 2'b11;
    req_addr_lo = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_idle("R8 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R8 after release");

    for (int i = 0; i < 64; i++) begin
      logic [31:0] d;
      d = $urandom;
      d[31] = (i % 8 == 7) || ($urandom % 4 == 0);
      host_write(6'(i), d);
    end
    for (int i = 0; i < 6; i++) host_check(6'($urandom), "R1 readback");

    host_write(6'd5, 32'h8000_3F5A);
    host_check(6'd5, "R1 directed readback");
    run_seq(6'd5, 8'h01, 2'b01, 2'd3, 1'b0);
    host_write(6'd62, 32'h0000_0AF0);
    host_write(6'd63, 32'h0000_150F);
    host_write(6'd0, 32'h8000_2AC3);
    run_seq(6'd62, 8'h80, 2'b10, 2'd2, 1'b1);
    run_seq(6'd62, 8'h10, 2'b10, 2'd1, 1'b0);
    run_seq(6'd0, 8'h04, 2'b00, 2'd0, 1'b0);
    run_seq(6'd5, 8'h02, 2'b11, 2'd1, 1'b1);

    for (int i = 0; i < 30; i++) begin
      run_seq(6'($urandom), 8'h01 << ($urandom % 8), 2'($urandom), 2'($urandom),
              1'($urandom));
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule